// File: doc/BRIEF.md
# Bit-Serial Boolean Logic Instruction Unit

This block runs the binary part of a controller program one instruction per clock. Each cycle it takes a 5-bit opcode and the value of the operand bit, which has already been fetched elsewhere. It keeps a result bit that the conditional operations use, a flag that marks the next scan as the start of a new operation step, a pending-OR bit for OR-of-AND chains, and a stack of saved states for nested parenthesised groups.

Scans combine an operand with the current result. The operand can be inverted first, and the combine is AND, OR or XOR. AND binds tighter than OR because a standalone OR separator closes one AND chain and opens the next one. Parenthesised groups save the outer state and evaluate an inner expression from a fresh start. The closing parenthesis links the inner result back, inverted if the group was opened in negated form. Conditional operations (assign, set, reset) drive a write strobe and a data bit to the operand store, and each one ends the operation step.

All state and outputs are registered. The result of an instruction is visible on the ports in the cycle after the instruction was presented. Opcodes that are not defined act as no-operations.

Top module: `bitlogic_unit`

## Requirements
- R1: After a synchronous active-low reset the outputs read: rlo_o 0, first_o 1, depth_o 0, err_o 0, wr_en_o 0, wr_data_o 0.
- R2: Scan opcodes are 1 (AND), 2 (AND-inverted), 3 (OR), 4 (OR-inverted), 5 (XOR) and 6 (XOR-inverted). While first_o is 1, a scan loads its scan result directly into the result, whatever its link type, and clears first_o.
- R3: The inverted scan forms (opcodes 2, 4, 6) use the complement of operand_i as the scan result. The plain forms (1, 3, 5) use operand_i unchanged.
- R4: While first_o is 0, a scan combines the result with the scan result using the opcode's link, evaluated strictly left to right.
- R5: The conditional opcodes are 18 (assign), 19 (set) and 20 (reset). In the next cycle assign gives wr_en_o=1 and wr_data_o equal to rlo_o. Set gives wr_en_o=rlo_o and wr_data_o=rlo_o. Reset gives wr_en_o=rlo_o and wr_data_o=0. rlo_o stays unchanged and first_o becomes 1. In every other cycle wr_en_o and wr_data_o are 0.
- R6: Opcode 14, the standalone OR separator, folds the current result into a pending-OR bit and sets first_o. rlo_o always reports the result ORed with the pending-OR bit.
- R7: The opening opcodes are 7 (AND), 8 (AND-negated), 9 (OR), 10 (OR-negated), 11 (XOR) and 12 (XOR-negated). Each one saves the result, the pending-OR bit, first_o and its link, raises depth_o by 1, sets first_o and clears the pending-OR bit. Closing opcode 13 takes the inner rlo_o and inverts it for a negated link. It then restores the saved state and links the inner value to it. If the saved first_o was 1, the inner value is loaded instead. After the close first_o is 0 and depth_o falls by 1.
- R8: Groups nest up to 7 levels, and any number of groups can follow one another at one level.
- R9: An opening opcode at depth 7, or opcode 13 at depth 0, sets err_o and changes nothing else. err_o stays set until reset.
- R10: Opcode 15 replaces rlo_o with its complement and leaves first_o alone. Opcode 16 forces rlo_o to 1 and opcode 17 forces it to 0. Both of these set first_o.
- R11: Opcode 0 and opcodes 21 to 31 change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_op | input | 5 | Opcode of the instruction in this cycle |
| operand_i | input | 1 | Fetched value of the operand bit |
| rlo_o | output | 1 | Effective result (result OR pending-OR) |
| first_o | output | 1 | Next scan starts a new operation step |
| depth_o | output | 3 | Current parenthesis nesting depth |
| err_o | output | 1 | Sticky parenthesis overflow/underflow flag |
| wr_en_o | output | 1 | Write strobe of a conditional operation |
| wr_data_o | output | 1 | Bit value to write when wr_en_o is 1 |

## Verification
Every instruction shows its effect on all outputs, write strobe included, exactly one clock after it is presented, and no result comes later than that. The bench drives each instruction half a period before the edge that takes it and compares rlo_o, first_o, depth_o, err_o, wr_en_o and wr_data_o half a period after that edge against a behavioural model, whose state it advanced when it drove the instruction. Directed checks read the ports at that same point, so an output that arrives a cycle early or a cycle late shows up as a mismatch.

// File: rtl/bitlogic_pkg.sv
// Package: opcode encoding, link kinds, stack frame and decoded control
// word shared by the logic unit and its submodules.
// Assumes: 5-bit opcode field; undefined codes decode to no operation.
package bitlogic_pkg;

    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP     = 5'd0,
        OP_A       = 5'd1,
        OP_AN      = 5'd2,
        OP_O       = 5'd3,
        OP_ON      = 5'd4,
        OP_X       = 5'd5,
        OP_XN      = 5'd6,
        OP_AOPEN   = 5'd7,
        OP_ANOPEN  = 5'd8,
        OP_OOPEN   = 5'd9,
        OP_ONOPEN  = 5'd10,
        OP_XOPEN   = 5'd11,
        OP_XNOPEN  = 5'd12,
        OP_CLOSE   = 5'd13,
        OP_ORSEP   = 5'd14,
        OP_NOT     = 5'd15,
        OP_SET     = 5'd16,
        OP_CLR     = 5'd17,
        OP_ASSIGN  = 5'd18,
        OP_SETBIT  = 5'd19,
        OP_RSTBIT  = 5'd20
    } op_e;

    typedef enum logic [1:0] {
        LK_AND = 2'd0,
        LK_OR  = 2'd1,
        LK_XOR = 2'd2
    } link_e;

    typedef struct packed {
        logic  neg;
        link_e kind;
    } link_t;

    typedef struct packed {
        logic  rlo;
        logic  orp;
        logic  first;
        link_t link;
    } frame_t;

    localparam int FRAME_W = $bits(frame_t);

    typedef struct packed {
        logic  scan;
        logic  invert;
        link_e kind;
        logic  open;
        logic  close;
        logic  orsep;
        logic  negate;
        logic  force_one;
        logic  force_zero;
        logic  c_assign;
        logic  c_set;
        logic  c_reset;
    } ctl_t;

    // Combine two bits according to a link kind.
    function automatic logic link_apply(link_e k, logic a, logic b);
        case (k)
            LK_AND:  return a & b;
            LK_OR:   return a | b;
            default: return a ^ b;
        endcase
    endfunction

endpackage

// File: rtl/bitlogic_decode.sv
// Decoder: turns the raw opcode into a one-hot-ish control word.
// Assumes: scan and opening codes are laid out in AND/OR/XOR pairs with the
// inverted form on the even code, so link and inversion come from arithmetic.
module bitlogic_decode
    import bitlogic_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    output ctl_t             ctl_o
);

    logic [2:0] scan_idx;
    logic [2:0] open_idx;

    // Offsets of the opcode inside the scan and opening groups.
    always_comb begin
        scan_idx = 3'(op_i - 5'd1);
        open_idx = 3'(op_i - 5'd7);
    end

    // Map each opcode onto its control fields.
    always_comb begin
        ctl_o = '0;
        if (op_i >= OP_A && op_i <= OP_XN) begin
            ctl_o.scan   = 1'b1;
            ctl_o.invert = scan_idx[0];
            ctl_o.kind   = link_e'(scan_idx[2:1]);
        end else if (op_i >= OP_AOPEN && op_i <= OP_XNOPEN) begin
            ctl_o.open   = 1'b1;
            ctl_o.invert = open_idx[0];
            ctl_o.kind   = link_e'(open_idx[2:1]);
        end else begin
            case (op_i)
                OP_CLOSE:  ctl_o.close      = 1'b1;
                OP_ORSEP:  ctl_o.orsep      = 1'b1;
                OP_NOT:    ctl_o.negate     = 1'b1;
                OP_SET:    ctl_o.force_one  = 1'b1;
                OP_CLR:    ctl_o.force_zero = 1'b1;
                OP_ASSIGN: ctl_o.c_assign   = 1'b1;
                OP_SETBIT: ctl_o.c_set      = 1'b1;
                OP_RSTBIT: ctl_o.c_reset    = 1'b1;
                default:   ctl_o            = '0;
            endcase
        end
    end

endmodule

// File: rtl/bitlogic_stack.sv
// Parenthesis stack: DEPTH register slots with a level counter.
// Assumes: the caller never pushes and pops in the same cycle; a push when
// full or a pop when empty is dropped here as well as upstream.
module bitlogic_stack #(
    parameter int DEPTH = 7,
    parameter int W     = 6,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  push_data_i,
    output logic [W-1:0]  top_o,
    output logic [LW-1:0] level_o,
    output logic          full_o,
    output logic          empty_o
);

    logic [LW-1:0] level_q;
    logic [W-1:0]  slot_w [DEPTH];
    logic          do_push;
    logic          do_pop;

    assign full_o  = (level_q == LW'(DEPTH));
    assign empty_o = (level_q == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o && !push_i;
    assign level_o = level_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] slot_q;

        // Capture the pushed frame when this slot is the next free one.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (do_push && level_q == LW'(i))
                slot_q <= push_data_i;
        end

        assign slot_w[i] = slot_q;
    end

    // Track how many slots hold a saved frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= '0;
        else if (do_push)
            level_q <= level_q + 1'b1;
        else if (do_pop)
            level_q <= level_q - 1'b1;
    end

    // Select the most recently pushed frame.
    always_comb begin
        top_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (level_q == LW'(i + 1))
                top_o = slot_w[i];
        end
    end

endmodule

// File: rtl/bitlogic_exec.sv
// Execution core: holds the result, pending-OR, first-scan and error bits,
// works out their next values from the decoded control word, and drives
// the registered write strobe of conditional operations.
// Assumes: at most one control field is set per cycle; the stack reports
// full/empty for the current level.
module bitlogic_exec
    import bitlogic_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ctl_t   ctl_i,
    input  logic   operand_i,
    input  frame_t top_i,
    input  logic   full_i,
    input  logic   empty_i,
    output logic   push_o,
    output logic   pop_o,
    output frame_t frame_o,
    output logic   rlo_o,
    output logic   first_o,
    output logic   err_o,
    output logic   wr_en_o,
    output logic   wr_data_o
);

    logic rlo_q, orp_q, first_q, err_q, wen_q, wdat_q;
    logic rlo_d, orp_d, first_d, err_d, wen_d, wdat_d;
    logic eff;
    logic scan_bit;
    logic inner;

    assign eff      = rlo_q | orp_q;
    assign scan_bit = operand_i ^ ctl_i.invert;
    assign inner    = eff ^ top_i.link.neg;

    // Frame saved by an opening parenthesis.
    always_comb begin
        frame_o.rlo       = rlo_q;
        frame_o.orp       = orp_q;
        frame_o.first     = first_q;
        frame_o.link.neg  = ctl_i.invert;
        frame_o.link.kind = ctl_i.kind;
    end

    // Next-state selection per instruction class.
    always_comb begin
        rlo_d   = rlo_q;
        orp_d   = orp_q;
        first_d = first_q;
        err_d   = err_q;
        wen_d   = 1'b0;
        wdat_d  = 1'b0;
        push_o  = 1'b0;
        pop_o   = 1'b0;
        if (ctl_i.scan) begin
            rlo_d   = first_q ? scan_bit : link_apply(ctl_i.kind, rlo_q, scan_bit);
            first_d = 1'b0;
        end else if (ctl_i.open) begin
            if (full_i) begin
                err_d = 1'b1;
            end else begin
                push_o  = 1'b1;
                first_d = 1'b1;
                orp_d   = 1'b0;
            end
        end else if (ctl_i.close) begin
            if (empty_i) begin
                err_d = 1'b1;
            end else begin
                pop_o   = 1'b1;
                rlo_d   = top_i.first ? inner
                                      : link_apply(top_i.link.kind, top_i.rlo, inner);
                orp_d   = top_i.orp;
                first_d = 1'b0;
            end
        end else if (ctl_i.orsep) begin
            orp_d   = eff;
            first_d = 1'b1;
        end else if (ctl_i.negate) begin
            rlo_d = ~eff;
            orp_d = 1'b0;
        end else if (ctl_i.force_one || ctl_i.force_zero) begin
            rlo_d   = ctl_i.force_one;
            orp_d   = 1'b0;
            first_d = 1'b1;
        end else if (ctl_i.c_assign || ctl_i.c_set || ctl_i.c_reset) begin
            rlo_d   = eff;
            orp_d   = 1'b0;
            first_d = 1'b1;
            wen_d   = ctl_i.c_assign | eff;
            wdat_d  = ctl_i.c_reset ? 1'b0 : eff;
        end
    end

    // State and output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rlo_q   <= 1'b0;
            orp_q   <= 1'b0;
            first_q <= 1'b1;
            err_q   <= 1'b0;
            wen_q   <= 1'b0;
            wdat_q  <= 1'b0;
        end else begin
            rlo_q   <= rlo_d;
            orp_q   <= orp_d;
            first_q <= first_d;
            err_q   <= err_d;
            wen_q   <= wen_d;
            wdat_q  <= wdat_d;
        end
    end

    assign rlo_o     = eff;
    assign first_o   = first_q;
    assign err_o     = err_q;
    assign wr_en_o   = wen_q;
    assign wr_data_o = wdat_q;

endmodule

// File: rtl/bitlogic_unit.sv
// Top level: boolean logic instruction unit. Decodes one opcode per cycle,
// runs it against the operand bit and drives the conditional write port.
// Assumes: operand_i is already the value of the addressed bit in the cycle
// the opcode is presented; all outputs are valid one cycle later.
module bitlogic_unit
    import bitlogic_pkg::*;
#(
    parameter int NEST_DEPTH = 7,
    localparam int DW        = $clog2(NEST_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] instr_op,
    input  logic             operand_i,
    output logic             rlo_o,
    output logic             first_o,
    output logic [DW-1:0]    depth_o,
    output logic             err_o,
    output logic             wr_en_o,
    output logic             wr_data_o
);

    ctl_t   ctl;
    frame_t push_frame;
    frame_t top_frame;
    logic   [FRAME_W-1:0] top_bits;
    logic   push, pop, full, empty;

    assign top_frame = frame_t'(top_bits);

    bitlogic_decode u_dec (
        .op_i  (instr_op),
        .ctl_o (ctl)
    );

    bitlogic_stack #(
        .DEPTH (NEST_DEPTH),
        .W     (FRAME_W)
    ) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (push_frame),
        .top_o       (top_bits),
        .level_o     (depth_o),
        .full_o      (full),
        .empty_o     (empty)
    );

    bitlogic_exec u_exe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl),
        .operand_i (operand_i),
        .top_i     (top_frame),
        .full_i    (full),
        .empty_i   (empty),
        .push_o    (push),
        .pop_o     (pop),
        .frame_o   (push_frame),
        .rlo_o     (rlo_o),
        .first_o   (first_o),
        .err_o     (err_o),
        .wr_en_o   (wr_en_o),
        .wr_data_o (wr_data_o)
    );

endmodule

// File: rtl/bitlogic_unit_chk.sv
// Checker: temporal properties of the logic unit, seen from its ports.
// Assumes: attached to every bitlogic_unit instance by the bind below.
module bitlogic_unit_chk
    import bitlogic_pkg::*;
#(
    parameter int NEST_DEPTH = 7,
    localparam int DW        = $clog2(NEST_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] instr_op,
    input logic             rlo_o,
    input logic             first_o,
    input logic [DW-1:0]    depth_o,
    input logic             err_o,
    input logic             wr_en_o
);

    logic is_cond, is_open, is_nop;

    assign is_cond = (instr_op == OP_ASSIGN) || (instr_op == OP_SETBIT) ||
                     (instr_op == OP_RSTBIT);
    assign is_open = (instr_op >= OP_AOPEN) && (instr_op <= OP_XNOPEN);
    assign is_nop  = (instr_op == OP_NOP) || (instr_op > OP_RSTBIT);

    // R5
    cond_keeps_rlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_cond |=> ($stable(rlo_o) && first_o));

    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_cond) |=> !wr_en_o);

    // R10
    set_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_op == OP_SET) |=> (rlo_o && first_o));

    // R10
    clr_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_op == OP_CLR) |=> (!rlo_o && first_o));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R9
    overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && depth_o == DW'(NEST_DEPTH)) |=> (err_o && $stable(depth_o)));

    // R7
    close_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_op == OP_CLOSE && depth_o != '0) |=> (depth_o == $past(depth_o) - 1'b1));

    // R11
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop |=> ($stable(rlo_o) && $stable(first_o) && $stable(depth_o) && !wr_en_o));

endmodule

bind bitlogic_unit bitlogic_unit_chk #(.NEST_DEPTH(NEST_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_op (instr_op),
    .rlo_o    (rlo_o),
    .first_o  (first_o),
    .depth_o  (depth_o),
    .err_o    (err_o),
    .wr_en_o  (wr_en_o)
);

// File: tb/bitlogic_unit_test.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus
// directed checks with hand-worked values.
module bitlogic_unit_test;

    localparam int NOP = 0, A = 1, AN = 2, O = 3, ON = 4, X = 5, XN = 6;
    localparam int AOP = 7, ANOP = 8, OOP = 9, ONOP = 10, XOP = 11, XNOP = 12;
    localparam int CLS = 13, SEP = 14, NEG = 15, SETR = 16, CLRR = 17;
    localparam int ASG = 18, SBIT = 19, RBIT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] instr_op = 5'd0;
    logic       operand_i = 1'b0;
    logic       rlo_o, first_o, err_o, wr_en_o, wr_data_o;
    logic [2:0] depth_o;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    string cur_tag = "R1";

    typedef struct {
        bit rlo;
        bit orp;
        bit fc;
        bit neg;
        int kind;
    } frm_t;

    bit   m_rlo, m_orp, m_fc, m_err, m_wen, m_wd;
    frm_t stk[$];

    bitlogic_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_op(instr_op), .operand_i(operand_i),
        .rlo_o(rlo_o), .first_o(first_o), .depth_o(depth_o), .err_o(err_o),
        .wr_en_o(wr_en_o), .wr_data_o(wr_data_o)
    );

    always #2 clk = ~clk;

    function automatic bit comb(int k, bit a, bit b);
        if (k == 0) return a && b;
        if (k == 1) return a || b;
        return a != b;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_rlo = 0; m_orp = 0; m_fc = 1; m_err = 0; m_wen = 0; m_wd = 0;
        stk.delete();
    endfunction

    function automatic void model_apply(int op, bit b);
        bit   e, s, inner;
        frm_t f;
        e = m_rlo || m_orp;
        m_wen = 0;
        m_wd = 0;
        if (op >= A && op <= XN) begin
            s = b ^ (((op - 1) % 2) == 1);
            m_rlo = m_fc ? s : comb((op - 1) / 2, m_rlo, s);
            m_fc = 0;
        end else if (op >= AOP && op <= XNOP) begin
            if (stk.size() == 7) m_err = 1;
            else begin
                f.rlo = m_rlo; f.orp = m_orp; f.fc = m_fc;
                f.neg = ((op - 7) % 2) == 1; f.kind = (op - 7) / 2;
                stk.push_back(f);
                m_fc = 1; m_orp = 0;
            end
        end else if (op == CLS) begin
            if (stk.size() == 0) m_err = 1;
            else begin
                f = stk.pop_back();
                inner = e ^ f.neg;
                m_rlo = f.fc ? inner : comb(f.kind, f.rlo, inner);
                m_orp = f.orp;
                m_fc = 0;
            end
        end else if (op == SEP) begin
            m_orp = e; m_fc = 1;
        end else if (op == NEG) begin
            m_rlo = !e; m_orp = 0;
        end else if (op == SETR || op == CLRR) begin
            m_rlo = (op == SETR); m_orp = 0; m_fc = 1;
        end else if (op == ASG || op == SBIT || op == RBIT) begin
            m_wen = (op == ASG) ? 1'b1 : e;
            m_wd = (op == RBIT) ? 1'b0 : e;
            m_rlo = e; m_orp = 0; m_fc = 1;
        end
    endfunction

    // Wait for the sampling point and compare every port with the model.
    task automatic tick();
        @(negedge clk);
        chk(cur_tag, "rlo_o", rlo_o, m_rlo || m_orp);
        chk(cur_tag, "first_o", first_o, m_fc);
        chk(cur_tag, "depth_o", depth_o, stk.size());
        chk(cur_tag, "err_o", err_o, m_err);
        chk(cur_tag, "wr_en_o", wr_en_o, m_wen);
        chk(cur_tag, "wr_data_o", wr_data_o, m_wd);
    endtask

    task automatic do_op(int op, bit b);
        instr_op = 5'(op);
        operand_i = b;
        model_apply(op, b);
        tick();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        instr_op = 5'(NOP);
        repeat (2) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        cur_tag = "R1";
        instr_op = 5'(NOP);
        tick();
        chk("R1", "reset rlo", rlo_o, 0);
        chk("R1", "reset first", first_o, 1);
        chk("R1", "reset depth", depth_o, 0);
        chk("R1", "reset wr_en", wr_en_o, 0);

        cur_tag = "R2";
        do_op(X, 1);
        chk("R2", "first XOR scan loads", rlo_o, 1);
        chk("R2", "first cleared", first_o, 0);

        cur_tag = "R3";
        do_op(CLRR, 0);
        do_op(AN, 0);
        chk("R3", "inverted first scan", rlo_o, 1);
        do_op(XN, 1);
        chk("R3", "XN of 1 keeps", rlo_o, 1);
        do_op(AN, 1);
        chk("R3", "AN of 1 clears", rlo_o, 0);

        cur_tag = "R4";
        do_op(SETR, 0);
        do_op(A, 1);
        do_op(X, 1);
        chk("R4", "1 xor 1", rlo_o, 0);
        do_op(O, 1);
        chk("R4", "0 or 1", rlo_o, 1);
        do_op(A, 0);
        chk("R4", "1 and 0", rlo_o, 0);

        cur_tag = "R5";
        do_op(SETR, 0);
        do_op(A, 1);
        do_op(A, 1);
        do_op(ASG, 0);
        chk("R5", "assign strobe", wr_en_o, 1);
        chk("R5", "assign data", wr_data_o, 1);
        chk("R5", "step ends", first_o, 1);
        do_op(SBIT, 0);
        chk("R5", "set strobe", wr_en_o, 1);
        chk("R5", "set keeps rlo", rlo_o, 1);
        do_op(A, 0);
        chk("R5", "new step loads 0", rlo_o, 0);
        chk("R5", "strobe drops", wr_en_o, 0);
        do_op(RBIT, 0);
        chk("R5", "reset gated by rlo 0", wr_en_o, 0);
        do_op(ASG, 1);
        chk("R5", "assign writes 0", wr_en_o, 1);
        chk("R5", "assign data 0", wr_data_o, 0);

        cur_tag = "R6";
        do_op(SETR, 0);
        do_op(A, 1);
        do_op(A, 0);
        do_op(SEP, 0);
        chk("R6", "separator marks first", first_o, 1);
        chk("R6", "pending 0", rlo_o, 0);
        do_op(A, 1);
        do_op(A, 1);
        chk("R6", "second chain true", rlo_o, 1);
        do_op(SEP, 0);
        do_op(A, 0);
        chk("R6", "pending keeps result", rlo_o, 1);
        do_op(ASG, 0);
        chk("R6", "assign of OR-of-AND", wr_data_o, 1);

        cur_tag = "R7";
        do_op(SETR, 0);
        do_op(A, 1);
        do_op(ANOP, 0);
        chk("R7", "open depth", depth_o, 1);
        chk("R7", "open fresh step", first_o, 1);
        do_op(O, 0);
        do_op(O, 0);
        do_op(CLS, 0);
        chk("R7", "negated AND group", rlo_o, 1);
        chk("R7", "close depth", depth_o, 0);
        do_op(SETR, 0);
        do_op(A, 0);
        do_op(OOP, 0);
        do_op(A, 1);
        do_op(CLS, 0);
        chk("R7", "OR group", rlo_o, 1);
        do_op(CLRR, 0);
        do_op(XNOP, 0);
        do_op(A, 0);
        do_op(CLS, 0);
        chk("R7", "group as first scan", rlo_o, 1);

        cur_tag = "R8";
        do_op(SETR, 0);
        do_op(AOP, 0);
        do_op(A, 1);
        do_op(CLS, 0);
        do_op(AOP, 0);
        do_op(A, 0);
        do_op(CLS, 0);
        chk("R8", "groups in a row", rlo_o, 0);

        cur_tag = "R10";
        do_op(SETR, 0);
        do_op(A, 1);
        do_op(NEG, 0);
        chk("R10", "not inverts", rlo_o, 0);
        chk("R10", "not keeps step", first_o, 0);
        do_op(A, 1);
        chk("R10", "scan after not links", rlo_o, 0);
        do_op(SETR, 0);
        chk("R10", "set forces 1", rlo_o, 1);
        do_op(CLRR, 0);
        chk("R10", "clr forces 0", rlo_o, 0);
        chk("R10", "clr ends step", first_o, 1);

        cur_tag = "R11";
        do_op(SETR, 0);
        do_op(A, 1);
        do_op(NOP, 1);
        chk("R11", "nop keeps rlo", rlo_o, 1);
        do_op(25, 0);
        chk("R11", "undefined keeps rlo", rlo_o, 1);
        chk("R11", "undefined no strobe", wr_en_o, 0);
        do_op(AOP, 0);
        do_op(31, 1);
        chk("R11", "undefined keeps depth", depth_o, 1);
        chk("R11", "undefined keeps first", first_o, 1);
        do_op(CLS, 0);

        cur_tag = "R8";
        do_reset();
        for (int i = 0; i < 7; i++) begin
            do_op(AOP, 0);
            do_op(A, 1);
        end
        chk("R8", "seven levels depth", depth_o, 7);
        chk("R8", "seven levels no error", err_o, 0);
        cur_tag = "R9";
        do_op(OOP, 0);
        chk("R9", "overflow flag", err_o, 1);
        chk("R9", "overflow depth held", depth_o, 7);
        for (int i = 0; i < 7; i++) do_op(CLS, 0);
        chk("R9", "unwound", depth_o, 0);
        do_op(CLS, 0);
        chk("R9", "underflow depth held", depth_o, 0);
        chk("R9", "error sticky", err_o, 1);
        cur_tag = "R1";
        do_reset();
        instr_op = 5'(NOP);
        tick();
        chk("R1", "reset clears error", err_o, 0);

        cur_tag = "R2/R4/R5/R6/R7/R10 random";
        for (int n = 0; n < 4000; n++) begin
            if (n % 700 == 0) do_reset();
            do_op(int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule